// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Timed Burst Line Fill

This block is a small direct-mapped data cache placed between a processor's load/store port and a slow main memory. A read that finds its line resident completes in the same cycle it is presented, with no wait states. A read that misses stalls the requester. The cache then fetches the whole line from memory as a burst of word-sized beats. The first beat of a burst needs a long access time and each later beat needs a shorter one. Once the last beat arrives the requested word is handed back and the line stays resident, so later reads anywhere in that line hit.

The memory side has no handshake. The cache itself counts the access time of each beat with programmable latencies. It drives the beat address and samples the memory data on the last cycle of each beat's window, so any memory that answers within that window can sit on the port. Writes always go straight through to memory in one cycle. A write that finds its line resident also updates the cached copy. A write that misses leaves the cache untouched. Two saturating counters record how many accesses hit and how many missed. From them the hit ratio and the average cycles per access can be derived.

Top module: `burst_fill_cache`

## Requirements
- R1: After reset every line is invalid: the first access to any address misses, both counters read zero, and `cpu_ready` is low while no request is presented.
- R2: A read whose line is resident with a matching tag raises `cpu_ready` in the cycle the request is presented and returns the cached word on `cpu_rdata`.
- R3: A read miss holds `cpu_ready` low and raises it after FIRST_LAT + (BEATS-1)*NEXT_LAT cycles, counted from and including the request cycle. With the defaults of 5, 2 and 4 beats this is 11 cycles, or 10 wait states.
- R4: During a fill `mem_rd` is high in every cycle. `mem_addr` presents the line base (byte offset zero) for the first FIRST_LAT cycles, and then base+4, base+8 and base+12 for NEXT_LAT cycles each, in that order.
- R5: The word returned at the end of a read miss equals the memory word at the requested address, whichever of the four words in the line was requested.
- R6: After a fill, reads of all four words of that line hit.
- R7: A write completes in the cycle it is presented: `cpu_ready`, `mem_we` high, `mem_addr` equal to `cpu_addr`, `mem_wdata` equal to `cpu_wdata`. This holds whether the write hits or misses.
- R8: A write that hits replaces the cached word, and a following read of that address hits and returns the written value.
- R9: A write that misses allocates nothing. The line previously held at that index still hits, and a later read of the written address misses and returns the written value from memory.
- R10: Two addresses with the same index and different tags evict each other. After the second is filled, the first misses again.
- R11: Each accepted access, read or write, adds one to exactly one counter: hits or misses. Each counter stops at 2^CNT_W-1.
- R12: Address fields: bits [1:0] pick a byte and are ignored for reads, bits [3:2] pick the word in the 16-byte line, the next log2(lines) bits form the index, and the remaining upper bits are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request; held with its address until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid when `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_rd | output | 1 | Memory read in progress (line fill) |
| mem_we | output | 1 | Memory write strobe (write-through) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, sampled at the end of each beat window |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
Two corners are hard to reach from the ports. The first is a miss on the last word of a line, where the returned data has to bypass the array in the same cycle the final beat is written. The second is a write miss that sits at an index already holding another tag. The bench builds a small 16-line configuration and fills every line with a miss whose word offset rotates through all four positions, so every word position is requested, including the bypass case. It then plants a write miss at an occupied index and reads both tags to show that nothing was allocated. Counter saturation is reached by hammering one resident address in the narrow-counter build.

// File: rtl/cache_pkg.sv
package cache_pkg;

    // Fill sequencer state.
    typedef enum logic {
        FILL_IDLE,
        FILL_BUSY
    } fill_state_e;

    // Classification of the access seen while the cache is idle.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_HIT,
        ACC_RD_MISS,
        ACC_WR_HIT,
        ACC_WR_MISS
    } access_e;

    function automatic access_e classify(input logic take, input logic is_wr, input logic hit);
        if (!take) return ACC_NONE;
        if (is_wr) return hit ? ACC_WR_HIT : ACC_WR_MISS;
        return hit ? ACC_RD_HIT : ACC_RD_MISS;
    endfunction

    function automatic logic is_hit(input access_e k);
        return (k == ACC_RD_HIT) || (k == ACC_WR_HIT);
    endfunction

    function automatic logic is_miss(input access_e k);
        return (k == ACC_RD_MISS) || (k == ACC_WR_MISS);
    endfunction

    function automatic logic is_write(input access_e k);
        return (k == ACC_WR_HIT) || (k == ACC_WR_MISS);
    endfunction

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int LINES = 512,
    parameter int IDX_W = 9,
    parameter int TAG_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[set_idx] <= set_tag;
        end
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // R1: the cycle after reset no line may be valid.
    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int LINES  = 512,
    parameter int BEATS  = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 9,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = LINES * BEATS;

    logic [DATA_W-1:0] word_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{wr_idx, wr_beat}] <= wr_data;
        end
    end

    assign rd_data = word_q[{rd_idx, rd_beat}];

endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl
    import cache_pkg::*;
#(
    parameter int FIRST_LAT = 5,
    parameter int NEXT_LAT  = 2,
    parameter int BEATS     = 4,
    localparam int BEAT_W   = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [BEAT_W-1:0] beat,
    output logic              beat_done,
    output logic              fill_last
);
    localparam int LAT_MAX = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
    localparam int LCNT_W  = $clog2(LAT_MAX + 1);
    localparam int TOTAL   = FIRST_LAT + (BEATS - 1) * NEXT_LAT;
    localparam int ELAP_W  = $clog2(TOTAL + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    fill_state_e       state_q;
    logic [LCNT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] beat_q;

    assign busy      = (state_q == FILL_BUSY);
    assign beat      = beat_q;
    assign beat_done = busy && (cnt_q == '0);
    assign fill_last = beat_done && (beat_q == LAST_BEAT);

    // The request cycle itself is the first cycle of beat 0, so the
    // busy phase starts with FIRST_LAT-2 cycles left before the sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_IDLE;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (start) begin
                        state_q <= FILL_BUSY;
                        cnt_q   <= LCNT_W'(FIRST_LAT - 2);
                        beat_q  <= '0;
                    end
                end
                default: begin
                    if (beat_done) begin
                        if (beat_q == LAST_BEAT) begin
                            state_q <= FILL_IDLE;
                            beat_q  <= '0;
                        end else begin
                            beat_q <= BEAT_W'(beat_q + 1'b1);
                            cnt_q  <= LCNT_W'(NEXT_LAT - 1);
                        end
                    end else begin
                        cnt_q <= LCNT_W'(cnt_q - 1'b1);
                    end
                end
            endcase
        end
    end

    // Independent cycle tally from the request cycle, for the checks below.
    logic [ELAP_W-1:0] elapsed_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
        end else if (!busy) begin
            elapsed_q <= start ? ELAP_W'(1) : '0;
        end else begin
            elapsed_q <= ELAP_W'(elapsed_q + 1'b1);
        end
    end

    // R3: the last beat lands exactly TOTAL-1 cycles after the request cycle.
    assert_fill_length_R3: assert property (@(posedge clk) disable iff (rst)
        fill_last |-> (elapsed_q == ELAP_W'(TOTAL - 1)));

    // R4: beats advance by at most one per cycle and never go backwards.
    assert_beat_order_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            ((beat_q == $past(beat_q)) || (beat_q == BEAT_W'($past(beat_q) + 1'b1))));

endmodule

// File: rtl/cache_stats.sv
module cache_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_ev,
    input  logic             miss_ev,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    logic [1:0]       ev;
    logic [CNT_W-1:0] cnt_q [2];

    assign ev = {miss_ev, hit_ev};

    for (genvar g = 0; g < 2; g++) begin : g_ctr
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[g] <= '0;
            end else if (ev[g] && (cnt_q[g] != '1)) begin
                cnt_q[g] <= CNT_W'(cnt_q[g] + 1'b1);
            end
        end

        // R11: a full counter stays full.
        assert_sat_hold_R11: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[g] == '1) |=> (cnt_q[g] == '1));

        // R11: a counter never moves down outside reset.
        assert_monotone_R11: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (cnt_q[g] >= $past(cnt_q[g])));
    end

    // R11: one access never bumps both counters.
    assert_one_event_R11: assert property (@(posedge clk) disable iff (rst)
        !(hit_ev && miss_ev));

    assign hit_count  = cnt_q[0];
    assign miss_count = cnt_q[1];

endmodule

// File: rtl/burst_fill_cache.sv
module burst_fill_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 8192,
    parameter int FIRST_LAT   = 5,
    parameter int NEXT_LAT    = 2,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINES  = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    // Address fields of the incoming request.
    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [BEAT_W-1:0] cpu_beat;
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
    assign cpu_beat = cpu_addr[BYTE_W +: BEAT_W];

    // Fill sequencer.
    logic              busy;
    logic [BEAT_W-1:0] beat;
    logic              beat_done;
    logic              fill_last;
    logic              start;

    // Request captured when a fill starts.
    logic [TAG_W-1:0]  fill_tag_q;
    logic [IDX_W-1:0]  fill_idx_q;
    logic [BEAT_W-1:0] fill_beat_q;

    logic    lk_hit;
    access_e kind;

    assign kind  = classify(cpu_req && !busy, cpu_we, lk_hit);
    assign start = (kind == ACC_RD_MISS);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_tag_q  <= '0;
            fill_idx_q  <= '0;
            fill_beat_q <= '0;
        end else if (start) begin
            fill_tag_q  <= cpu_tag;
            fill_idx_q  <= cpu_idx;
            fill_beat_q <= cpu_beat;
        end
    end

    cache_fill_ctrl #(
        .FIRST_LAT (FIRST_LAT),
        .NEXT_LAT  (NEXT_LAT),
        .BEATS     (BEATS)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy      (busy),
        .beat      (beat),
        .beat_done (beat_done),
        .fill_last (fill_last)
    );

    cache_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .lk_idx  (cpu_idx),
        .lk_tag  (cpu_tag),
        .lk_hit  (lk_hit),
        .set_en  (fill_last),
        .set_idx (fill_idx_q),
        .set_tag (fill_tag_q)
    );

    // Data array ports: the fill owns them while busy, the CPU otherwise.
    logic              dw_en;
    logic [IDX_W-1:0]  dw_idx;
    logic [BEAT_W-1:0] dw_beat;
    logic [DATA_W-1:0] dw_data;
    logic [IDX_W-1:0]  dr_idx;
    logic [BEAT_W-1:0] dr_beat;
    logic [DATA_W-1:0] dr_data;

    always_comb begin
        dw_en   = beat_done || (kind == ACC_WR_HIT);
        dw_idx  = busy ? fill_idx_q : cpu_idx;
        dw_beat = busy ? beat       : cpu_beat;
        dw_data = busy ? mem_rdata  : cpu_wdata;
        dr_idx  = busy ? fill_idx_q  : cpu_idx;
        dr_beat = busy ? fill_beat_q : cpu_beat;
    end

    cache_data_store #(
        .LINES  (LINES),
        .BEATS  (BEATS),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .BEAT_W (BEAT_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (dw_en),
        .wr_idx  (dw_idx),
        .wr_beat (dw_beat),
        .wr_data (dw_data),
        .rd_idx  (dr_idx),
        .rd_beat (dr_beat),
        .rd_data (dr_data)
    );

    // The last beat is written at the same edge the answer is given, so a
    // request for that word takes it straight from the memory bus.
    assign cpu_rdata = (busy && (fill_beat_q == LAST_BEAT)) ? mem_rdata : dr_data;
    assign cpu_ready = busy ? fill_last : (is_hit(kind) || is_write(kind));

    always_comb begin
        mem_rd    = start || busy;
        mem_we    = is_write(kind);
        mem_wdata = cpu_wdata;
        if (busy) begin
            mem_addr = {fill_tag_q, fill_idx_q, beat, {BYTE_W{1'b0}}};
        end else if (start) begin
            mem_addr = {cpu_tag, cpu_idx, {OFF_W{1'b0}}};
        end else begin
            mem_addr = cpu_addr;
        end
    end

    cache_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk        (clk),
        .rst        (rst),
        .hit_ev     (is_hit(kind)),
        .miss_ev    (is_miss(kind)),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    // R7: a presented write completes at once and reaches memory.
    assert_write_through_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && !busy) |-> (cpu_ready && mem_we && (mem_addr == cpu_addr)));

    // R7: no memory write is issued while a fill owns the bus.
    assert_no_write_in_fill_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_we);

    // R3: the requester is stalled until the final beat.
    assert_stall_until_last_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && !fill_last) |-> !cpu_ready);

    // R6: a line that has just been filled answers a repeat of the same read.
    assert_filled_line_hits_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_last && cpu_req && !cpu_we) |=>
            ((cpu_req && !cpu_we && $stable(cpu_addr)) -> lk_hit));

endmodule

// File: tb/sim_burst_fill_cache.sv
module sim_burst_fill_cache;
    localparam int PER = 10;
    localparam int AW  = 12;
    localparam int CW  = 8;
    localparam int MISS_CYC = 5 + 3 * 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [31:0]   cpu_wdata, cpu_rdata;
    logic          cpu_ready, mem_rd, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic [CW-1:0] hit_count, miss_count;

    always #(PER/2) clk = ~clk;

    burst_fill_cache #(
        .ADDR_W(AW), .DATA_W(32), .LINE_BYTES(16), .CACHE_BYTES(256),
        .FIRST_LAT(5), .NEXT_LAT(2), .CNT_W(CW)
    ) u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0001_0003);
    endfunction

    // Memory model driven by the design, and a shadow kept by the bench.
    logic [31:0] bmem [1024];
    logic [31:0] shadow [1024];
    initial for (int i = 0; i < 1024; i++) begin bmem[i] = pat(i); shadow[i] = pat(i); end
    always @(posedge clk) if (mem_we) bmem[mem_addr[11:2]] <= mem_wdata;
    assign mem_rdata = bmem[mem_addr[11:2]];

    int tests = 0, fails = 0;
    int eh = 0, em = 0;
    logic       mv [16];
    logic [3:0] mt [16];

    logic [AW-1:0] alog [32];
    logic          rlog [32];
    logic          s_we;
    logic [AW-1:0] s_addr;
    logic [31:0]   s_wd;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          output int cyc, output logic [31:0] rd);
        bit done = 0;
        cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        cyc = 0; rd = '0;
        while (!done) begin
            #1;
            if (cyc < 32) begin alog[cyc] = mem_addr; rlog[cyc] = mem_rd; end
            cyc++;
            if (cpu_ready) begin
                rd = cpu_rdata; s_we = mem_we; s_addr = mem_addr; s_wd = mem_wdata;
                done = 1;
            end else if (cyc > 40) begin
                done = 1;
            end
            @(negedge clk);
        end
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic bump(bit h);
        if (h) begin if (eh < 255) eh++; end
        else   begin if (em < 255) em++; end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int cyc; logic [31:0] rd;
        logic [3:0] ix = a[7:4];
        logic [3:0] tg = a[11:8];
        bit h = mv[ix] && (mt[ix] == tg);
        access(1'b0, a, 32'h0, cyc, rd);
        if (h) begin
            check("R2 hit cycles", 32'(cyc), 32'd1);
            check("R2/R6/R12 hit data", rd, shadow[a[11:2]]);
        end else begin
            check("R3 miss cycles", 32'(cyc), 32'(MISS_CYC));
            check("R5/R12 miss data", rd, shadow[a[11:2]]);
            for (int c = 0; c < MISS_CYC; c++) begin
                int b = (c < 5) ? 0 : 1 + (c - 5) / 2;
                check("R4 burst addr", 32'(alog[c]), 32'({tg, ix, 2'(b), 2'b00}));
                check("R4 burst rd", 32'(rlog[c]), 32'd1);
            end
            mv[ix] = 1'b1; mt[ix] = tg;
        end
        bump(h);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        int cyc; logic [31:0] rd;
        bit h = mv[a[7:4]] && (mt[a[7:4]] == a[11:8]);
        access(1'b1, a, d, cyc, rd);
        check("R7 write cycles", 32'(cyc), 32'd1);
        check("R7 mem_we", 32'(s_we), 32'd1);
        check("R7 mem_addr", 32'(s_addr), 32'(a));
        check("R7 mem_wdata", s_wd, d);
        shadow[a[11:2]] = d;
        bump(h);
    endtask

    task automatic check_counts(string tag);
        check({"R11 hits ", tag}, 32'(hit_count), 32'(eh));
        check({"R11 misses ", tag}, 32'(miss_count), 32'(em));
    endtask

    initial begin
        #(PER * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mv[i] = 1'b0; mt[i] = '0; end
        rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 ready idle", 32'(cpu_ready), 32'd0);
        check_counts("R1 reset");
        @(negedge clk);

        // R1/R3/R4/R5: first touch of every line misses; word offset rotates.
        for (int ix = 0; ix < 16; ix++)
            do_read({4'h0, 4'(ix), 2'(ix % 4), 2'(ix % 4)});
        check_counts("after fills");

        // R6/R12: every word of every filled line hits, byte bits varied.
        for (int ix = 0; ix < 16; ix++)
            for (int w = 0; w < 4; w++)
                do_read({4'h0, 4'(ix), 2'(w), 2'((ix + w) % 4)});
        check_counts("after hit sweep");

        // R10: same index, different tag evicts.
        do_read({4'h1, 4'h3, 2'd2, 2'd0});
        do_read({4'h0, 4'h3, 2'd2, 2'd1});
        do_read({4'h0, 4'h3, 2'd0, 2'd0});

        // R8: write hit updates cached word.
        do_write({4'h0, 4'h5, 2'd1, 2'd0}, 32'hDEAD_0001);
        do_read({4'h0, 4'h5, 2'd1, 2'd0});

        // R9: write miss at occupied index does not allocate.
        do_write({4'h2, 4'h6, 2'd3, 2'd0}, 32'hBEEF_0009);
        do_read({4'h0, 4'h6, 2'd0, 2'd0});
        do_read({4'h2, 4'h6, 2'd3, 2'd0});
        do_read({4'h0, 4'h6, 2'd0, 2'd0});
        check_counts("after writes");

        // R11: saturation of the hit counter.
        for (int k = 0; k < 260; k++) do_read({4'h2, 4'h6, 2'd1, 2'd2});
        check("R11 hit saturate", 32'(hit_count), 32'd255);
        check_counts("saturated");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule